// File: doc/BRIEF.md
# Indexed Register Access Bridge

This block lets a host that owns only eight byte offsets of I/O space reach a 256-byte register space inside a peripheral. The host first loads an index register through one offset. It then reads or writes the target register that the index selects through other offsets. Two of these offsets advance the index after the access, so a run of consecutive registers can be walked without reloading the index. Another offset reads the index back, and one more starts a fixed-length reset pulse to the peripheral.

Target strobes, address and write data are driven combinationally in the same cycle as the host strobe. The target returns read data combinationally, and the bridge registers it onto the host read bus.

The reset pulse comes from a two-state machine:
- `RS_IDLE` moves to `RS_PULSE` on the transition *reset command*, which is a host write at offset 0.
- `RS_PULSE` holds a down-counter. It returns to `RS_IDLE` on the transition *count done*, when the counter reaches zero.
- `tgt_rst` is high exactly while the machine is in `RS_PULSE`.

Top module: `idx_reg_bridge`

## Requirements
- R1: After system reset, the index register (visible on `tgt_addr`) is 0x00, `tgt_rst` is low and `host_rdata` is 0x00.
- R2: A host write at offset 1 loads the index register with `host_wdata`. The new value appears on `tgt_addr` in the following cycle.
- R3: A host read at offset 2 pulses `tgt_rd` with `tgt_addr` equal to the index. The target byte appears on `host_rdata` one cycle after the strobe and stays there until the next host read. The index is unchanged.
- R4: A host read at offset 3 behaves as R3 using the index value from before the access. The index then increases by one in the following cycle.
- R5: A host read at offset 5 returns the current index value on `host_rdata` one cycle after the strobe.
- R6: A host write at offset 6 pulses `tgt_wr` in the same cycle, with `tgt_addr` equal to the index and `tgt_wdata` equal to `host_wdata`. The index is unchanged.
- R7: A host write at offset 7 behaves as R6 using the index value from before the access. The index then increases by one in the following cycle.
- R8: The index increment wraps from 0xFF to 0x00.
- R9: A host write of any value at offset 0 raises `tgt_rst` in the next cycle and holds it high for exactly 16 cycles. An offset-0 write made while the pulse is running does not lengthen it.
- R10: Host reads at offsets 0, 1, 4, 6 and 7 return 0x00. Host writes at offsets 2, 3, 4 and 5 have no effect. Neither kind of access strobes the target or changes the index.
- R11: The target reset pulse does not change the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| host_off | input | 3 | Host byte offset within the eight-byte window |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rdata | output | 8 | Registered host read data |
| tgt_addr | output | 8 | Target register address (current index) |
| tgt_wdata | output | 8 | Target write data |
| tgt_rdata | input | 8 | Target read data, valid in the cycle `tgt_rd` is high |
| tgt_rd | output | 1 | Target read strobe |
| tgt_wr | output | 1 | Target write strobe |
| tgt_rst | output | 1 | Target reset output, active high |

## Verification
Target strobes, target address and write data are due in the same cycle as the host strobe. Index updates, read data and the rising edge of `tgt_rst` are due one clock edge later. The bench drives every strobe for one cycle from a falling edge and samples at the next falling edge, which sits after exactly the one rising edge that carries these results. The length of the reset pulse is measured by counting high samples on successive falling edges until the output drops. Every effect on the index is observed through the offset-5 readback, never by peeking inside the design.

// File: rtl/idx_bridge_pkg.sv
package idx_bridge_pkg;

    typedef enum logic [2:0] {
        OFF_TRST  = 3'd0,
        OFF_ALOAD = 3'd1,
        OFF_RD    = 3'd2,
        OFF_RDINC = 3'd3,
        OFF_SPARE = 3'd4,
        OFF_AREAD = 3'd5,
        OFF_WR    = 3'd6,
        OFF_WRINC = 3'd7
    } host_off_e;

    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_PULSE = 1'b1
    } rst_state_e;

    typedef struct packed {
        logic addr_load;
        logic addr_inc;
        logic tgt_rd;
        logic tgt_wr;
        logic trst_req;
        logic sel_tgt;
        logic sel_addr;
    } dec_t;

endpackage

// File: rtl/idx_bridge_decode.sv
module idx_bridge_decode
    import idx_bridge_pkg::*;
(
    input  logic [2:0] host_off,
    input  logic       host_rd,
    input  logic       host_wr,
    output dec_t       dec
);

    host_off_e off;
    assign off = host_off_e'(host_off);

    always_comb begin
        dec = '0;
        unique case (off)
            OFF_TRST:  dec.trst_req  = host_wr;
            OFF_ALOAD: dec.addr_load = host_wr;
            OFF_RD: begin
                dec.tgt_rd  = host_rd;
                dec.sel_tgt = host_rd;
            end
            OFF_RDINC: begin
                dec.tgt_rd   = host_rd;
                dec.sel_tgt  = host_rd;
                dec.addr_inc = host_rd;
            end
            OFF_SPARE: ;
            OFF_AREAD: dec.sel_addr = host_rd;
            OFF_WR:    dec.tgt_wr   = host_wr;
            OFF_WRINC: begin
                dec.tgt_wr   = host_wr;
                dec.addr_inc = host_wr;
            end
        endcase
    end

endmodule

// File: rtl/idx_bridge_addr.sv
module idx_bridge_addr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc)
            addr <= addr + ONE;   // wraps naturally at the top of the space
    end

endmodule

// File: rtl/idx_bridge_rstgen.sv
module idx_bridge_rstgen
    import idx_bridge_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic tgt_rst
);

    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(RST_CYCLES - 1);

    rst_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state: reset command / count done
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            RS_IDLE: begin
                if (req) begin
                    state_nx = RS_PULSE;
                    cnt_nx   = LOAD_VAL;
                end
            end
            RS_PULSE: begin
                if (cnt == '0)
                    state_nx = RS_IDLE;
                else
                    cnt_nx = cnt - CW'(1);
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            RS_IDLE:  tgt_rst = 1'b0;
            RS_PULSE: tgt_rst = 1'b1;
        endcase
    end

endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
    import idx_bridge_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    host_off,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  logic          host_wr,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    input  logic [DW-1:0] tgt_rdata,
    output logic          tgt_rd,
    output logic          tgt_wr,
    output logic          tgt_rst
);

    dec_t dec;

    idx_bridge_decode u_dec (
        .host_off (host_off),
        .host_rd  (host_rd),
        .host_wr  (host_wr),
        .dec      (dec)
    );

    idx_bridge_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dec.addr_load),
        .inc      (dec.addr_inc),
        .load_val (host_wdata[AW-1:0]),
        .addr     (tgt_addr)
    );

    idx_bridge_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (dec.trst_req),
        .tgt_rst (tgt_rst)
    );

    assign tgt_rd    = dec.tgt_rd;
    assign tgt_wr    = dec.tgt_wr;
    assign tgt_wdata = host_wdata;

    logic [DW-1:0] rd_mux;
    always_comb begin
        if (dec.sel_tgt)
            rd_mux = tgt_rdata;
        else if (dec.sel_addr)
            rd_mux = DW'(tgt_addr);
        else
            rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (host_rd)
            host_rdata <= rd_mux;
    end

endmodule

// File: rtl/idx_reg_bridge_chk.sv
module idx_reg_bridge_chk #(
    parameter int DW         = 8,
    parameter int AW         = 8,
    parameter int RST_CYCLES = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    host_off,
    input logic [DW-1:0] host_wdata,
    input logic          host_rd,
    input logic          host_wr,
    input logic [DW-1:0] host_rdata,
    input logic [AW-1:0] tgt_addr,
    input logic          tgt_rd,
    input logic          tgt_wr,
    input logic          tgt_rst
);

    logic [31:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= '0;
        else if (tgt_rst) run_len <= run_len + 32'd1;
        else              run_len <= '0;
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_off == 3'd1 |=> tgt_addr == $past(host_wdata[AW-1:0]));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && host_off == 3'd2 |=> $stable(tgt_addr));

    a_r4_rdinc: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_wr && host_off == 3'd3 |=> tgt_addr == AW'($past(tgt_addr) + AW'(1)));

    a_r7_wrinc: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && !host_rd && host_off == 3'd7 |=> tgt_addr == AW'($past(tgt_addr) + AW'(1)));

    a_r5_aread: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_off == 3'd5 |=> host_rdata == DW'($past(tgt_addr)));

    a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_off == 3'd0 |=> tgt_rst);

    a_r9_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_rst) |-> run_len == 32'(RST_CYCLES));

    a_r9_max: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 32'(RST_CYCLES));

    a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_off == 3'd0 || host_off == 3'd1 || host_off == 3'd4 ||
                    host_off == 3'd6 || host_off == 3'd7) |=> host_rdata == '0);

    a_r10_no_wstrobe: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> host_wr && host_off[2:1] == 2'b11);

    a_r10_no_rstrobe: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd |-> host_rd && host_off[2:1] == 2'b01);

endmodule

bind idx_reg_bridge idx_reg_bridge_chk #(
    .DW(DW), .AW(AW), .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_off   (host_off),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .tgt_addr   (tgt_addr),
    .tgt_rd     (tgt_rd),
    .tgt_wr     (tgt_wr),
    .tgt_rst    (tgt_rst)
);

// File: tb/idx_reg_bridge_tb.sv
module idx_reg_bridge_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_off = '0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_rdata, tgt_addr, tgt_wdata, tgt_rdata;
    logic       tgt_rd, tgt_wr, tgt_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    idx_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .tgt_rd(tgt_rd), .tgt_wr(tgt_wr), .tgt_rst(tgt_rst)
    );

    // target register file model
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (tgt_wr) begin
            mem[tgt_addr] <= tgt_wdata;
        end
    end
    assign tgt_rdata = mem[tgt_addr];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        host_off = off; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        host_off = off; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset;
        chk("R1 index", tgt_addr, 8'h00);
        chk("R1 tgt_rst", {7'd0, tgt_rst}, 8'h00);
        chk("R1 rdata", host_rdata, 8'h00);
    endtask

    task automatic t_load_read;
        logic [7:0] d;
        hwrite(3'd1, 8'h37);
        hread(3'd5, d);  chk("R2 load readback", d, 8'h37);
        chk("R5 readback", d, 8'h37);
        hread(3'd2, d);  chk("R3 plain read", d, 8'h37 ^ 8'h5A);
        hread(3'd5, d);  chk("R3 index held", d, 8'h37);
    endtask

    task automatic t_rdinc;
        logic [7:0] d;
        hwrite(3'd1, 8'h10);
        for (int i = 0; i < 3; i++) begin
            hread(3'd3, d);
            chk("R4 burst read", d, 8'(8'h10 + i) ^ 8'h5A);
        end
        hread(3'd5, d);  chk("R4 index advanced", d, 8'h13);
    endtask

    task automatic t_write;
        logic [7:0] d;
        hwrite(3'd1, 8'h80);
        @(negedge clk);
        host_off = 3'd6; host_wdata = 8'hC3; host_wr = 1'b1;
        #1;
        chk("R6 tgt_wr same cycle", {7'd0, tgt_wr}, 8'h01);
        chk("R6 tgt_addr", tgt_addr, 8'h80);
        chk("R6 tgt_wdata", tgt_wdata, 8'hC3);
        @(negedge clk);
        host_wr = 1'b0;
        chk("R6 stored", mem[8'h80], 8'hC3);
        hread(3'd5, d);  chk("R6 index held", d, 8'h80);
        hwrite(3'd7, 8'hA1);
        hwrite(3'd7, 8'hA2);
        chk("R7 first", mem[8'h80], 8'hA1);
        chk("R7 second", mem[8'h81], 8'hA2);
        hread(3'd5, d);  chk("R7 index advanced", d, 8'h82);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        hwrite(3'd1, 8'hFE);
        hread(3'd3, d);  chk("R8 read FE", d, 8'hFE ^ 8'h5A);
        hread(3'd3, d);  chk("R8 read FF", d, 8'hFF ^ 8'h5A);
        hread(3'd5, d);  chk("R8 read wrap", d, 8'h00);
        hwrite(3'd1, 8'hFF);
        hwrite(3'd7, 8'h66);
        chk("R8 write FF", mem[8'hFF], 8'h66);
        hread(3'd5, d);  chk("R8 write wrap", d, 8'h00);
    endtask

    task automatic t_ignored;
        logic [7:0] d;
        logic [7:0] snap;
        hwrite(3'd1, 8'h20);
        snap = mem[8'h20];
        for (int o = 2; o <= 5; o++) begin
            hwrite(3'(o), 8'hEE);
            chk("R10 no target write", mem[8'h20], snap);
            hread(3'd5, d);
            chk("R10 index after write", d, 8'h20);
        end
        for (int k = 0; k < 5; k++) begin
            logic [2:0] o;
            o = (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : (k == 2) ? 3'd4 : (k == 3) ? 3'd6 : 3'd7;
            hread(o, d);
            chk("R10 read zero", d, 8'h00);
            hread(3'd5, d);
            chk("R10 index after read", d, 8'h20);
        end
    endtask

    task automatic measure_pulse(output int n);
        n = 0;
        while (tgt_rst === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_trst;
        logic [7:0] d;
        int n;
        hwrite(3'd1, 8'h42);
        hwrite(3'd0, 8'h00);
        chk("R9 rise", {7'd0, tgt_rst}, 8'h01);
        measure_pulse(n);
        chk("R9 width", 8'(n), 8'd16);
        hread(3'd5, d);  chk("R11 index kept", d, 8'h42);
        hwrite(3'd0, 8'hFF);
        repeat (4) @(negedge clk);
        host_off = 3'd0; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        measure_pulse(n);
        chk("R9 no extend", 8'(n + 5), 8'd16);
        chk("R9 low after", {7'd0, tgt_rst}, 8'h00);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=done");
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_rdinc();
        t_write();
        t_wrap();
        t_ignored();
        t_trst();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule